// File: doc/BRIEF.md
# UART Diagnostic Loopback Switch

This block does the pin-side switching for a single UART channel. It sits between the serial transmitter and receiver cores and the channel's four pins: serial in, serial out, clear-to-send and request-to-send. A 2-bit channel-mode field selects one of three paths. In normal mode the cores connect straight to the pins. In local loopback the transmitter talks to its own receiver inside the chip. In remote loopback the far end's data is echoed back out of the channel.

Each mode changes more than the serial data path. It also overrides the transmit flow-control check, the request-to-send drive, the effective receiver enable, the receive FIFO write strobe and the receive error-check enable. In remote loopback the incoming line is synchronised into the core clock domain and then retimed on the 16x sample tick before it is driven out. This gives the echo a fixed and bounded delay.

Top module: `uart_loop_switch`

## Requirements
- R1: The mode field decodes as follows: 2'b00 is normal, 2'b01 is local loopback and 2'b10 is remote loopback. The value 2'b11 behaves exactly like normal.
- R2: In normal mode `dout_pin` equals `tx_serial`, `rx_serial` equals `din_pin`, `rx_active` equals `rx_en` and `rx_fifo_wr` equals `rx_wr_req`. `rx_err_chk_en` is 1.
- R3: In normal mode `tx_go` = `tx_en & (cts_pin | ~cts_chk_en)`, and `rts_pin` = `rts_en & rts_req`.
- R4: In local loopback `rx_serial` equals `tx_serial` and `dout_pin` is held at 1. `din_pin` has no effect on any output.
- R5: In local loopback `tx_go` equals `tx_en` whatever the CTS inputs are, `rts_pin` is 0 and `rx_active` is 1. `rx_fifo_wr` follows `rx_wr_req` and `rx_err_chk_en` is 1.
- R6: In remote loopback `dout_pin` carries `din_pin` after SYNC_STAGES core-clock flops and one retiming flop. When `sample_tick` is held high, a change on `din_pin` reaches `dout_pin` exactly SYNC_STAGES+1 rising edges later.
- R7: The retimed output changes only on a clock edge at which `sample_tick` is high.
- R8: In remote loopback `rx_fifo_wr` is 0, `rx_err_chk_en` is 0 and `tx_go` equals `tx_en` whatever the CTS inputs are. `rx_active`, `rx_serial` and `rts_pin` follow the normal-mode rules.
- R9: While `rst_n` is low, every synchroniser and retiming flop is loaded with 1, so `dout_pin` is 1 in remote loopback during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_mode | input | 2 | Channel mode select (see R1) |
| sample_tick | input | 1 | 16x bit-rate enable for retiming |
| tx_serial | input | 1 | Serial output of the transmitter core |
| tx_en | input | 1 | Transmitter enable bit |
| cts_chk_en | input | 1 | Enable for the clear-to-send check |
| cts_pin | input | 1 | Clear-to-send pin, 1 = peer ready |
| rts_en | input | 1 | Enable for receiver-driven request-to-send |
| rts_req | input | 1 | Receiver's request-to-send level |
| rx_en | input | 1 | Receiver enable bit |
| rx_wr_req | input | 1 | Receiver's FIFO write request |
| din_pin | input | 1 | Serial input pin |
| dout_pin | output | 1 | Serial output pin |
| rts_pin | output | 1 | Request-to-send pin |
| rx_serial | output | 1 | Serial input to the receiver core |
| tx_go | output | 1 | Transmitter allowed to send |
| rx_active | output | 1 | Effective receiver enable |
| rx_fifo_wr | output | 1 | Gated receive FIFO write strobe |
| rx_err_chk_en | output | 1 | Receive error checking enabled |

## Verification
Nearly all outputs are combinational functions of the mode and the core-side inputs. A wrong decode or a wrong gate therefore shows up at the pins in the same cycle as the input pattern that exposes it. A bad retiming chain shows up as an echo that arrives a cycle early or late, or as an echo that moves on an edge without a sample tick. Both are visible on `dout_pin` within SYNC_STAGES+1 edges of a `din_pin` change. A wrong reset value in the chain shows as `dout_pin` low during reset.

// File: rtl/uls_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the loopback switch.
// Holds the channel-mode encoding and the decoded one-hot mode flags.
package uls_pkg;
    typedef enum logic [1:0] {
        CM_NORMAL = 2'b00,
        CM_LOCAL  = 2'b01,
        CM_REMOTE = 2'b10,
        CM_ALT    = 2'b11
    } chan_mode_e;

    typedef struct packed {
        logic normal;
        logic local_lb;
        logic remote_lb;
    } mode_flags_t;
endpackage

// File: rtl/uls_mode_decode.sv
`timescale 1ns/1ps
// Module: uls_mode_decode
// Turns the 2-bit mode field into one-hot flags.
// Assumes: the unused code is folded onto normal operation.
module uls_mode_decode
    import uls_pkg::*;
(
    input  logic [1:0]  chan_mode,
    output mode_flags_t flags
);
    // Purpose: map each mode code to exactly one active flag.
    always_comb begin
        flags = '0;
        case (chan_mode_e'(chan_mode))
            CM_LOCAL:  flags.local_lb  = 1'b1;
            CM_REMOTE: flags.remote_lb = 1'b1;
            default:   flags.normal    = 1'b1;
        endcase
    end
endmodule

// File: rtl/uls_reclock.sv
`timescale 1ns/1ps
// Module: uls_reclock
// Brings the asynchronous serial input into the clock domain through
// STAGES flops, then retimes it on the 16x sample tick.
// Assumes: STAGES >= 2; the line idles high, so all flops reset to 1.
module uls_reclock #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_sync
            // Purpose: one synchroniser stage, reset to idle level.
            always_ff @(posedge clk) begin
                if (!rst_n)       sync_q[gi] <= 1'b1;
                else if (gi == 0) sync_q[gi] <= din;
                else              sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi - 1];
            end
        end
    endgenerate

    // Purpose: retime the synchronised bit on the sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b1;
        else if (tick) q <= sync_q[LAST];
    end

    // R7: the retimed output moves only on a ticked edge
    a_r7_retime_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (q != $past(q)) |-> $past(tick));
endmodule

// File: rtl/uls_gate.sv
`timescale 1ns/1ps
// Module: uls_gate
// Applies the mode-dependent overrides to flow control, enables,
// FIFO writes and error checking.
// Assumes: flags are one-hot; cts_pin high means the peer is ready.
module uls_gate
    import uls_pkg::*;
(
    input  mode_flags_t flags,
    input  logic        tx_en,
    input  logic        cts_chk_en,
    input  logic        cts_pin,
    input  logic        rts_en,
    input  logic        rts_req,
    input  logic        rx_en,
    input  logic        rx_wr_req,
    output logic        tx_go,
    output logic        rts_pin,
    output logic        rx_active,
    output logic        rx_fifo_wr,
    output logic        rx_err_chk_en
);
    logic cts_bypass;

    // Purpose: decide whether the CTS check is skipped in this mode.
    always_comb cts_bypass = flags.local_lb | flags.remote_lb;

    // Purpose: transmit permission with the flow-control gate.
    always_comb tx_go = tx_en & (cts_bypass | ~cts_chk_en | cts_pin);

    // Purpose: RTS drive, silenced in local loopback.
    always_comb rts_pin = ~flags.local_lb & rts_en & rts_req;

    // Purpose: receiver forced on in local loopback.
    always_comb rx_active = flags.local_lb | rx_en;

    // Purpose: no FIFO writes and no error checks while echoing.
    always_comb begin
        rx_fifo_wr    = rx_wr_req & ~flags.remote_lb;
        rx_err_chk_en = ~flags.remote_lb;
    end
endmodule

// File: rtl/uart_loop_switch.sv
`timescale 1ns/1ps
// Module: uart_loop_switch
// Pin-side switch for one UART channel: normal, local loopback and
// remote loopback, with the mode-dependent gating overrides.
// Assumes: din_pin is asynchronous; sample_tick is a one-cycle 16x enable.
module uart_loop_switch
    import uls_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] chan_mode,
    input  logic       sample_tick,
    input  logic       tx_serial,
    input  logic       tx_en,
    input  logic       cts_chk_en,
    input  logic       cts_pin,
    input  logic       rts_en,
    input  logic       rts_req,
    input  logic       rx_en,
    input  logic       rx_wr_req,
    input  logic       din_pin,
    output logic       dout_pin,
    output logic       rts_pin,
    output logic       rx_serial,
    output logic       tx_go,
    output logic       rx_active,
    output logic       rx_fifo_wr,
    output logic       rx_err_chk_en
);
    mode_flags_t flags;
    logic        echo_bit;

    uls_mode_decode u_dec (
        .chan_mode (chan_mode),
        .flags     (flags)
    );

    uls_reclock #(.STAGES(SYNC_STAGES)) u_reclk (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sample_tick),
        .din   (din_pin),
        .q     (echo_bit)
    );

    uls_gate u_gate (
        .flags         (flags),
        .tx_en         (tx_en),
        .cts_chk_en    (cts_chk_en),
        .cts_pin       (cts_pin),
        .rts_en        (rts_en),
        .rts_req       (rts_req),
        .rx_en         (rx_en),
        .rx_wr_req     (rx_wr_req),
        .tx_go         (tx_go),
        .rts_pin       (rts_pin),
        .rx_active     (rx_active),
        .rx_fifo_wr    (rx_fifo_wr),
        .rx_err_chk_en (rx_err_chk_en)
    );

    // Purpose: choose the serial-out source for the mode.
    always_comb begin
        if (flags.remote_lb)     dout_pin = echo_bit;
        else if (flags.local_lb) dout_pin = 1'b1;
        else                     dout_pin = tx_serial;
    end

    // Purpose: choose the receiver's serial source for the mode.
    always_comb rx_serial = flags.local_lb ? tx_serial : din_pin;

    // R4: local loopback keeps the line idle
    a_r4_local_dout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'b01) |-> dout_pin);

    // R5: no RTS while looped locally
    a_r5_local_no_rts: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'b01) |-> !rts_pin);

    // R8: echo mode never writes the FIFO
    a_r8_remote_no_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'b10) |-> (!rx_fifo_wr && !rx_err_chk_en));

    // R3: normal mode honours a blocking CTS
    a_r3_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.normal && cts_chk_en && !cts_pin) |-> !tx_go);
endmodule

// File: tb/uart_loop_switch_tb.sv
`timescale 1ns/1ps
module uart_loop_switch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;

    typedef struct {
        logic [1:0] mode;
        logic dout; logic dout_chk;
        logic rxs; logic go; logic rts; logic act; logic wr; logic chk;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic [1:0] chan_mode = 2'b00;
    logic sample_tick = 0, tx_serial = 1, tx_en = 0, cts_chk_en = 0, cts_pin = 0;
    logic rts_en = 0, rts_req = 0, rx_en = 0, rx_wr_req = 0, din_pin = 1;
    logic dout_pin, rts_pin, rx_serial, tx_go, rx_active, rx_fifo_wr, rx_err_chk_en;

    int n_run = 0, n_fail = 0;
    exp_t sb_q[$];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_loop_switch #(.SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .chan_mode(chan_mode), .sample_tick(sample_tick),
        .tx_serial(tx_serial), .tx_en(tx_en), .cts_chk_en(cts_chk_en), .cts_pin(cts_pin),
        .rts_en(rts_en), .rts_req(rts_req), .rx_en(rx_en), .rx_wr_req(rx_wr_req),
        .din_pin(din_pin), .dout_pin(dout_pin), .rts_pin(rts_pin), .rx_serial(rx_serial),
        .tx_go(tx_go), .rx_active(rx_active), .rx_fifo_wr(rx_fifo_wr),
        .rx_err_chk_en(rx_err_chk_en)
    );

    task automatic chk(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic string tag(logic [1:0] m, string nrm, string loc, string rem);
        if (m == 2'b01) return loc;
        if (m == 2'b10) return rem;
        return nrm;
    endfunction

    // Driver: apply one pattern and push what the requirements predict
    task automatic drive(logic [1:0] m, logic [8:0] v);
        exp_t e;
        @(negedge clk);
        chan_mode = m;
        {tx_serial, tx_en, cts_chk_en, cts_pin, rts_en, rts_req, rx_en, rx_wr_req, din_pin} = v;
        e.mode = m;
        e.dout_chk = (m != 2'b10);
        e.dout = (m == 2'b01) ? 1'b1 : v[8];
        e.rxs  = (m == 2'b01) ? v[8] : v[0];
        if (m == 2'b01 || m == 2'b10) e.go = v[7];
        else e.go = v[7] & (v[5] | ~v[6]);
        e.rts  = (m == 2'b01) ? 1'b0 : (v[4] & v[3]);
        e.act  = (m == 2'b01) ? 1'b1 : v[2];
        e.wr   = (m == 2'b10) ? 1'b0 : v[1];
        e.chk  = (m != 2'b10);
        sb_q.push_back(e);
    endtask

    // Monitor: compare after the following rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.dout_chk) chk(tag(e.mode, "R1/R2 dout", "R4 dout", "R6"), dout_pin, e.dout);
                chk(tag(e.mode, "R2 rx_serial", "R4 rx_serial", "R8 rx_serial"), rx_serial, e.rxs);
                chk(tag(e.mode, "R3 tx_go", "R5 tx_go", "R8 tx_go"), tx_go, e.go);
                chk(tag(e.mode, "R3 rts", "R5 rts", "R8 rts"), rts_pin, e.rts);
                chk(tag(e.mode, "R2 rx_active", "R5 rx_active", "R8 rx_active"), rx_active, e.act);
                chk(tag(e.mode, "R2 fifo_wr", "R5 fifo_wr", "R8 fifo_wr"), rx_fifo_wr, e.wr);
                chk(tag(e.mode, "R2 err_chk", "R5 err_chk", "R8 err_chk"), rx_err_chk_en, e.chk);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: remote mode during reset, din low, line still idle
        chan_mode = 2'b10; din_pin = 0; sample_tick = 1;
        repeat (4) @(posedge clk);
        #1 chk("R9 dout in reset", dout_pin, 1'b1);
        @(negedge clk); rst_n = 1; din_pin = 1;
        repeat (SYNC + 2) @(posedge clk);

        // R1..R5, R8: every mode against every core-side pattern
        for (int m = 0; m < 4; m++)
            for (int v = 0; v < 512; v++)
                drive(2'(m), 9'(v));
        wait (sb_q.size() == 0);

        // R6: latency with the tick held high
        @(negedge clk); chan_mode = 2'b10; sample_tick = 1; din_pin = 1;
        repeat (SYNC + 2) @(posedge clk);
        @(negedge clk); din_pin = 0;
        for (int k = 1; k <= SYNC + 1; k++) begin
            @(posedge clk); #1;
            chk("R6 echo latency", dout_pin, (k == SYNC + 1) ? 1'b0 : 1'b1);
        end
        // R6: rising edge of din
        @(negedge clk); din_pin = 1;
        for (int k = 1; k <= SYNC + 1; k++) begin
            @(posedge clk); #1;
            chk("R6 echo latency rise", dout_pin, (k == SYNC + 1) ? 1'b1 : 1'b0);
        end

        // R7: without a tick the echo holds
        @(negedge clk); din_pin = 0; sample_tick = 0;
        repeat (SYNC + 4) @(posedge clk);
        #1 chk("R7 hold without tick", dout_pin, 1'b1);
        @(negedge clk); sample_tick = 1;
        @(posedge clk); #1 chk("R7 update on tick", dout_pin, 1'b0);
        @(negedge clk); sample_tick = 0; din_pin = 1;
        repeat (SYNC + 3) @(posedge clk);
        #1 chk("R7 hold again", dout_pin, 1'b0);

        // R4: din toggling in local mode never reaches dout
        @(negedge clk); chan_mode = 2'b01; tx_serial = 0; sample_tick = 1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); din_pin = ~din_pin;
            @(posedge clk); #1;
            chk("R4 din ignored dout", dout_pin, 1'b1);
            chk("R4 din ignored rx_serial", rx_serial, 1'b0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule